// File: doc/BRIEF.md
# Ten-bit I2C Target Address Matcher

This block decides whether an I2C target that owns a fixed 10-bit address is being selected, and whether it should act as a receiver or a transmitter. It sits above a byte-level bus front end. That front end reports three conditions as one-cycle pulses: a fresh START, a repeated START and a STOP. It also delivers each received address byte with a one-cycle valid strobe. The matcher answers every byte with a registered acknowledge decision. It also drives an "addressed" flag and a direction flag, where 1 means the target transmits.

A 10-bit selection takes two bytes. The first is a header made of the reserved mark `11110`, the two upper address bits and a direction bit of 0. The second byte carries the low eight address bits. Once selected, the target keeps that state across a repeated START, so a later header with direction bit 1 turns it into a transmitter without a second address byte. A read header that arrives with no such earlier selection cannot open a transaction, and the block ignores it. A parameter switches the block to plain 7-bit matching, so that the 10-bit path can be compared against ordinary addresses.

Top module: `tenbit_addr_match`

## Requirements
- R1: After reset, `ack_o`, `addressed_o` and `xmit_o` are 0 and the block waits for a header byte.
- R2: After START, a byte equal to {`11110`, ADDR[9:8], 0} (0xF4 for the default address 0x2A5) is acknowledged. `ack_o` is high for exactly the one cycle after the edge that samples the strobe.
- R3: A header with the wrong upper address bits is not acknowledged. A byte that is not a valid header while waiting for one is not acknowledged and changes no flag.
- R4: In the byte right after an acknowledged write header, a value equal to ADDR[7:0] is acknowledged, sets `addressed_o` and clears `xmit_o`. Any other value is not acknowledged, and the block returns to waiting for a header.
- R5: Once addressed, later bytes give no acknowledge from this block and leave `addressed_o` and `xmit_o` unchanged. A repeated START alone does not clear `addressed_o`.
- R6: After a repeated START that follows a selection, the header {`11110`, ADDR[9:8], 1} is acknowledged and sets `xmit_o`, and the target stays addressed.
- R7: A header with direction bit 1 from a target that was not addressed just before the repeated START (or after a fresh START) is ignored: no acknowledge and no selection.
- R8: A repeated START followed by a write header discards the previous selection (`addressed_o` falls) and restarts the two-byte match. A repeated START followed by any other non-matching byte also deselects the target.
- R9: A STOP or a fresh START clears the selection, the memory of earlier selection and any partial match. A read header after a following repeated START is then ignored.
- R10: A START or repeated START that arrives while the block waits for the low address byte aborts the partial match. The next byte is then treated as a header.
- R11: With `TEN_BIT` = 0, a byte whose upper seven bits equal `TGT_ADDR7` is acknowledged after START or repeated START. It selects the target with `xmit_o` equal to bit 0 of that byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | One-cycle pulse on a fresh START |
| rstart_i | input | 1 | One-cycle pulse on a repeated START |
| stop_i | input | 1 | One-cycle pulse on a STOP |
| byte_vld_i | input | 1 | Strobe for a received byte |
| byte_i | input | 8 | Received byte, MSB first on the bus, bit 0 is the direction bit for headers |
| ack_o | output | 1 | Acknowledge decision, one cycle after the strobe |
| addressed_o | output | 1 | Target currently selected |
| xmit_o | output | 1 | 1 when selected as transmitter |

## Verification
On every cycle, the in-RTL assertions check four things. An acknowledge only ever follows a byte strobe. A STOP always leaves the target deselected and silent. A selected target stays selected with a steady direction while no bus condition occurs. Transmitter and receiver selection are reached only from the remembered-selection state and the low-byte state respectively. The bench's scenarios show the content-dependent results: which header values and low bytes are accepted, the read header after a selection versus after a STOP, and aborts in the middle of a match. A behavioural model checks all three outputs of a 10-bit instance and a 7-bit instance on every clock.

// File: rtl/tam_pkg.sv
package tam_pkg;
   typedef enum logic [1:0] {
      ST_IDLE = 2'd0,  // waiting for a header byte, no earlier selection
      ST_LOW  = 2'd1,  // write header matched, low address byte expected
      ST_ADDR = 2'd2,  // selected
      ST_HOLD = 2'd3   // selected before a repeated START, header pending
   } tam_state_e;

   localparam logic [4:0] TAM_HDR_MARK = 5'b11110;
endpackage

// File: rtl/tam_hdr_decode.sv
module tam_hdr_decode
   import tam_pkg::*;
#(
   parameter int                ADDR_W    = 10,
   parameter logic [ADDR_W-1:0] TGT_ADDR  = 10'h2A5,
   parameter bit                TEN_BIT   = 1'b1,
   parameter logic [6:0]        TGT_ADDR7 = 7'h3C
) (
   input  logic [7:0] byte_i,
   output logic       hdr_wr_hit_o,
   output logic       hdr_rd_hit_o,
   output logic       lo_hit_o
);
   localparam int HI_W = ADDR_W - 8;

   generate
      if (TEN_BIT) begin : g_ten
         logic [6:0] hdr_key;
         assign hdr_key      = {TAM_HDR_MARK, TGT_ADDR[ADDR_W-1 -: HI_W]};
         assign hdr_wr_hit_o = (byte_i[7:1] == hdr_key) && !byte_i[0];
         assign hdr_rd_hit_o = (byte_i[7:1] == hdr_key) &&  byte_i[0];
         assign lo_hit_o     = (byte_i == TGT_ADDR[7:0]);
      end else begin : g_seven
         assign hdr_wr_hit_o = (byte_i[7:1] == TGT_ADDR7) && !byte_i[0];
         assign hdr_rd_hit_o = (byte_i[7:1] == TGT_ADDR7) &&  byte_i[0];
         assign lo_hit_o     = 1'b0;
      end
   endgenerate
endmodule

// File: rtl/tam_ctrl.sv
module tam_ctrl
   import tam_pkg::*;
#(
   parameter bit TEN_BIT = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic start_i,
   input  logic rstart_i,
   input  logic stop_i,
   input  logic byte_vld_i,
   input  logic hdr_wr_hit_i,
   input  logic hdr_rd_hit_i,
   input  logic lo_hit_i,
   output logic ack_o,
   output logic addressed_o,
   output logic xmit_o
);
   tam_state_e state_q, state_d;
   logic       xmit_q, xmit_d;
   logic       ack_q, hit_d;

   always_comb begin
      state_d = state_q;
      xmit_d  = xmit_q;
      hit_d   = 1'b0;
      if (stop_i || start_i) begin
         state_d = ST_IDLE;
         xmit_d  = 1'b0;
      end else if (rstart_i) begin
         // remember a selection across the repeated START; drop partial matches
         state_d = (state_q == ST_ADDR || state_q == ST_HOLD) ? ST_HOLD : ST_IDLE;
      end else if (byte_vld_i) begin
         case (state_q)
            ST_IDLE: begin
               if (TEN_BIT) begin
                  if (hdr_wr_hit_i) begin
                     hit_d   = 1'b1;
                     state_d = ST_LOW;
                  end
               end else if (hdr_wr_hit_i || hdr_rd_hit_i) begin
                  hit_d   = 1'b1;
                  state_d = ST_ADDR;
                  xmit_d  = hdr_rd_hit_i;
               end
            end
            ST_HOLD: begin
               hit_d   = 1'b1;
               xmit_d  = 1'b0;
               if (TEN_BIT && hdr_wr_hit_i) begin
                  state_d = ST_LOW;
               end else if (hdr_rd_hit_i || (!TEN_BIT && hdr_wr_hit_i)) begin
                  state_d = ST_ADDR;
                  xmit_d  = hdr_rd_hit_i;
               end else begin
                  hit_d   = 1'b0;
                  state_d = ST_IDLE;
               end
            end
            ST_LOW: begin
               xmit_d = 1'b0;
               if (lo_hit_i) begin
                  hit_d   = 1'b1;
                  state_d = ST_ADDR;
               end else begin
                  state_d = ST_IDLE;
               end
            end
            default: ;  // ST_ADDR: data bytes belong to another block
         endcase
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q <= ST_IDLE;
         xmit_q  <= 1'b0;
         ack_q   <= 1'b0;
      end else begin
         state_q <= state_d;
         xmit_q  <= xmit_d;
         ack_q   <= hit_d;
      end
   end

   assign ack_o       = ack_q;
   assign addressed_o = (state_q == ST_ADDR) || (state_q == ST_HOLD);
   assign xmit_o      = xmit_q;

   // R2: an acknowledge only follows a byte strobe
   assert_ack_after_strobe_R2: assert property (@(posedge clk) disable iff (!rst_n)
      ack_o |-> $past(byte_vld_i));

   // R9: STOP leaves the target deselected and silent
   assert_stop_clears_R9: assert property (@(posedge clk) disable iff (!rst_n)
      stop_i |=> (!addressed_o && !ack_o && !xmit_o));

   // R5: selection and direction stay put while no bus condition occurs
   assert_sel_holds_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == ST_ADDR && !stop_i && !start_i && !rstart_i)
      |=> (addressed_o && $stable(xmit_o)));

   generate
      if (TEN_BIT) begin : g_ten_chk
         // R7: transmitter role only from a remembered selection
         assert_read_needs_memory_R7: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(xmit_o) |-> ($past(state_q) == ST_HOLD));
         // R4: receiver selection only through the low-byte step
         assert_rx_via_low_R4: assert property (@(posedge clk) disable iff (!rst_n)
            ($rose(addressed_o) && !xmit_o) |-> ($past(state_q) == ST_LOW));
      end
   endgenerate
endmodule

// File: rtl/tenbit_addr_match.sv
module tenbit_addr_match
   import tam_pkg::*;
#(
   parameter int                ADDR_W    = 10,
   parameter logic [ADDR_W-1:0] TGT_ADDR  = 10'h2A5,
   parameter bit                TEN_BIT   = 1'b1,
   parameter logic [6:0]        TGT_ADDR7 = 7'h3C
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       start_i,
   input  logic       rstart_i,
   input  logic       stop_i,
   input  logic       byte_vld_i,
   input  logic [7:0] byte_i,
   output logic       ack_o,
   output logic       addressed_o,
   output logic       xmit_o
);
   generate
      if (ADDR_W != 10) begin : g_bad_width
         $error("tenbit_addr_match: ADDR_W must be 10");
      end
      if (!TEN_BIT && (TGT_ADDR7[6:2] == TAM_HDR_MARK)) begin : g_bad_seven
         $error("tenbit_addr_match: 7-bit address collides with the 10-bit header mark");
      end
   endgenerate

   logic hdr_wr_hit, hdr_rd_hit, lo_hit;

   tam_hdr_decode #(
      .ADDR_W   (ADDR_W),
      .TGT_ADDR (TGT_ADDR),
      .TEN_BIT  (TEN_BIT),
      .TGT_ADDR7(TGT_ADDR7)
   ) u_dec (
      .byte_i      (byte_i),
      .hdr_wr_hit_o(hdr_wr_hit),
      .hdr_rd_hit_o(hdr_rd_hit),
      .lo_hit_o    (lo_hit)
   );

   tam_ctrl #(
      .TEN_BIT(TEN_BIT)
   ) u_ctrl (
      .clk         (clk),
      .rst_n       (rst_n),
      .start_i     (start_i),
      .rstart_i    (rstart_i),
      .stop_i      (stop_i),
      .byte_vld_i  (byte_vld_i),
      .hdr_wr_hit_i(hdr_wr_hit),
      .hdr_rd_hit_i(hdr_rd_hit),
      .lo_hit_i    (lo_hit),
      .ack_o       (ack_o),
      .addressed_o (addressed_o),
      .xmit_o      (xmit_o)
   );
endmodule

// File: tb/sim_tenbit_addr_match.sv
module sim_tenbit_addr_match;
   localparam int CLK_P = 10;
   localparam logic [9:0] A10 = 10'h2A5;   // header write 0xF4, read 0xF5, low 0xA5
   localparam logic [6:0] A7  = 7'h3C;     // write 0x78, read 0x79

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic st = 1'b0, rs = 1'b0, sp = 1'b0, vld = 1'b0;
   logic [7:0] bt = 8'h00;
   logic [1:0] ack, adr, tx;

   int total = 0, bad = 0;
   string cur_req = "R1";

   // behavioural reference state, index 0 = 10-bit instance, 1 = 7-bit
   bit e_ack[2], e_adr[2], e_tx[2], want_low[2], sel_before[2];

   always #(CLK_P/2) clk = ~clk;

   tenbit_addr_match #(.TGT_ADDR(A10), .TEN_BIT(1'b1), .TGT_ADDR7(A7)) u0 (
      .clk(clk), .rst_n(rst_n), .start_i(st), .rstart_i(rs), .stop_i(sp),
      .byte_vld_i(vld), .byte_i(bt), .ack_o(ack[0]), .addressed_o(adr[0]), .xmit_o(tx[0]));

   tenbit_addr_match #(.TGT_ADDR(A10), .TEN_BIT(1'b0), .TGT_ADDR7(A7)) u1 (
      .clk(clk), .rst_n(rst_n), .start_i(st), .rstart_i(rs), .stop_i(sp),
      .byte_vld_i(vld), .byte_i(bt), .ack_o(ack[1]), .addressed_o(adr[1]), .xmit_o(tx[1]));

   task automatic model_step(input int k);
      logic [7:0] wr_h, rd_h;
      wr_h = {5'b11110, A10[9:8], 1'b0};
      rd_h = {5'b11110, A10[9:8], 1'b1};
      e_ack[k] = 1'b0;
      if (sp || st) begin
         e_adr[k] = 0; e_tx[k] = 0; want_low[k] = 0; sel_before[k] = 0;
      end else if (rs) begin
         sel_before[k] = e_adr[k];
         want_low[k]   = 0;
      end else if (vld) begin
         if (k == 0) begin
            if (want_low[k]) begin
               want_low[k] = 0;
               if (bt == A10[7:0]) begin e_ack[k] = 1; e_adr[k] = 1; e_tx[k] = 0; end
            end else if (sel_before[k]) begin
               sel_before[k] = 0;
               if (bt == wr_h) begin e_ack[k] = 1; want_low[k] = 1; e_adr[k] = 0; e_tx[k] = 0; end
               else if (bt == rd_h) begin e_ack[k] = 1; e_adr[k] = 1; e_tx[k] = 1; end
               else begin e_adr[k] = 0; e_tx[k] = 0; end
            end else if (!e_adr[k]) begin
               if (bt == wr_h) begin e_ack[k] = 1; want_low[k] = 1; end
            end
         end else begin
            if (sel_before[k] || !e_adr[k]) begin
               sel_before[k] = 0;
               if (bt[7:1] == A7) begin e_ack[k] = 1; e_adr[k] = 1; e_tx[k] = bt[0]; end
               else begin e_adr[k] = 0; e_tx[k] = 0; end
            end
         end
      end
   endtask

   task automatic compare_all();
      for (int k = 0; k < 2; k++) begin
         total++;
         if ({ack[k], adr[k], tx[k]} !== {e_ack[k], e_adr[k], e_tx[k]}) begin
            bad++;
            $display("FAIL %s u%0d ack/addressed/xmit got %b%b%b expected %b%b%b at %0t",
                     cur_req, k, ack[k], adr[k], tx[k], e_ack[k], e_adr[k], e_tx[k], $time);
         end
      end
   endtask

   // one clock: check outputs produced by the last edge, then drive and advance the model
   task automatic cyc(input logic s, input logic r, input logic p, input logic v, input logic [7:0] b);
      @(negedge clk);
      compare_all();
      st = s; rs = r; sp = p; vld = v; bt = b;
      model_step(0);
      model_step(1);
   endtask

   task automatic idle(); cyc(0, 0, 0, 0, 8'h00); endtask
   task automatic do_start(); cyc(1, 0, 0, 0, 8'h00); endtask
   task automatic do_rstart(); cyc(0, 1, 0, 0, 8'h00); endtask
   task automatic do_stop(); cyc(0, 0, 1, 0, 8'h00); endtask
   task automatic give(input logic [7:0] b); cyc(0, 0, 0, 1, b); idle(); endtask

   initial begin
      #(CLK_P * 50000);
      bad++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      for (int k = 0; k < 2; k++) begin
         e_ack[k] = 0; e_adr[k] = 0; e_tx[k] = 0; want_low[k] = 0; sel_before[k] = 0;
      end
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      cur_req = "R1"; idle(); idle();

      cur_req = "R2"; do_start(); give(8'hF4);
      cur_req = "R4"; give(8'hA5);
      cur_req = "R5"; give(8'hF4); give(8'h00); do_rstart(); idle();
      cur_req = "R6"; give(8'hF5); give(8'h5A);
      cur_req = "R9"; do_stop(); idle();

      cur_req = "R7"; do_start(); give(8'hF5); do_rstart(); give(8'hF5);
      do_stop();

      cur_req = "R3"; do_start(); give(8'hF6); give(8'hA5); give(8'h12);
      cur_req = "R4"; give(8'hF4); give(8'hA4); give(8'hA5);
      do_stop();

      cur_req = "R8"; do_start(); give(8'hF4); give(8'hA5);
      do_rstart(); give(8'hF4); give(8'hA5);
      do_rstart(); give(8'hF0); do_rstart(); give(8'hF5);
      do_stop();

      cur_req = "R10"; do_start(); give(8'hF4); do_rstart(); give(8'hA5);
      give(8'hF4); give(8'hA5);
      do_start(); give(8'hF4); do_start(); give(8'hA5);
      do_stop();

      cur_req = "R9"; do_start(); give(8'hF4); give(8'hA5); do_stop();
      do_rstart(); give(8'hF5); do_start(); give(8'hF4); do_start(); give(8'hA5);
      do_stop();

      cur_req = "R11"; do_start(); give(8'h79); give(8'h33); do_stop();
      do_start(); give(8'h78); do_rstart(); give(8'h79);
      do_rstart(); give(8'h10); give(8'h7A); do_stop(); idle();

      idle();
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule